// File: doc/BRIEF.md
# PDM Speaker Output Modulator

This block turns 24-bit PCM audio frames into a single-wire pulse-density-modulated bit stream for a digital speaker codec. It reads left/right frames from a first-word-fall-through receive FIFO. A second-order sigma-delta modulator runs for each channel. The block also drives the codec clock, which it makes by dividing the core clock by four. Each codec clock period carries two bit slots. The first slot is valid while the codec clock is high and the second while it is low. A stereo stream puts one channel in each slot. A single-channel stream fills the unused slot with an idle pattern of 50% density.

The oversampling ratio sets how many codec periods one PCM sample lasts: 32, 64, 128 or 256. The core clock must therefore run at oversampling ratio × sample rate × 4. The block supports sample rates from 8 kHz to 48 kHz with one or two channels. Software chooses between left, right and stereo output, and between left-first and right-first slot order. The enable, the slot order and the channel choice only take effect at a codec period boundary. When the FIFO has no frame at a load point, the block repeats the previous sample and raises a sticky underflow flag.

Top module: `pdmspk_top`

## Requirements
- R1: `codec_clk_o` has one quarter of the core clock rate. It is high during the first two core cycles of every codec period and low during the last two, and it is high in the first cycle after reset.
- R2: While the block is enabled and the FIFO supplies data, successive pops are 32, 64, 128 or 256 codec periods apart (4× that in core cycles), for `osr_sel_i` = 0, 1, 2 or 3 respectively.
- R3: After reset the block is disabled. `pdm_dat_o` is 0, `fifo_pop_o` is 0 while `en_i` is low, and `underflow_o` is 0.
- R4: Each channel runs one modulator step per codec period. The bit for the coming period is 1 when the second integrator is non-negative before the step. Let F be +2^23 for a 1 bit and −2^23 for a 0 bit, and let x be the sample in force for that period. The step is then: first integrator += x − F; second integrator += (new first integrator) − F.
- R5: With `ch_sel_i` = 3 (stereo), the high half of the codec period carries the left bit when `lr_swap_i` = 0 and the right bit when it is 1. The other channel occupies the low half.
- R6: `ch_sel_i` = 1 outputs the left channel only and 2 outputs the right channel only. The chosen channel keeps the half given by R5, and the other half carries the idle bit.
- R7: When a load point finds `fifo_valid_i` low, the previous sample is reused and `underflow_o` is set. The flag stays set until the block is disabled.
- R8: If `en_i` is low at a period boundary, both integrators and `underflow_o` are cleared, and both halves of every following period carry the idle bit. The idle bit is 0 in the period that starts at reset and inverts at every period boundary.
- R9: `en_i`, `ch_sel_i` and `lr_swap_i` act only in the last core cycle of a codec period. A change made earlier in a period leaves the rest of that period unchanged, and an enable seen at a boundary pops a frame in that same cycle.
- R10: `fifo_pop_o` is asserted only when `fifo_valid_i` is high and only in the last core cycle of a codec period. The frame on the data inputs is consumed at that same clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, four times the PDM bit clock |
| rst | input | 1 | Synchronous active-high reset |
| en_i | input | 1 | Run enable, sampled at codec period boundaries |
| osr_sel_i | input | 2 | Oversampling ratio select: 0=32, 1=64, 2=128, 3=256 |
| ch_sel_i | input | 2 | Output channels: 1=left, 2=right, 3=stereo |
| lr_swap_i | input | 1 | 0 puts left in the high half, 1 puts right there |
| fifo_valid_i | input | 1 | FIFO holds a frame |
| fifo_left_i | input | SAMPLE_W | Left sample of the head frame, two's complement |
| fifo_right_i | input | SAMPLE_W | Right sample of the head frame, two's complement |
| fifo_pop_o | output | 1 | Consume the head frame at this edge |
| codec_clk_o | output | 1 | Codec clock, core clock divided by four |
| pdm_dat_o | output | 1 | Pulse-density-modulated data |
| underflow_o | output | 1 | Sticky flag: a load point found the FIFO empty |

## Verification
Assertions check the fixed 2-high/2-low shape of the codec clock on every cycle. They also check that a pop only happens with valid data in the last low cycle before a rising codec clock, that the underflow flag never drops while enabled, that a modulator bit holds between steps, and that a disabled block repeats the same bit across both halves of a period. The exact bit sequence the modulator produces can only be shown by the bench, which runs a behavioural model through many patterns. The same applies to the slot mapping under each channel choice and swap setting, to the pop spacing for each ratio, to the reuse of the held sample in an underflow, and to the boundary-aligned effect of a mid-period enable.

// File: rtl/pdmspk_pkg.sv
package pdmspk_pkg;

    // Output channel choice as carried on ch_sel_i
    typedef enum logic [1:0] {
        CH_RSVD  = 2'd0,
        CH_LEFT  = 2'd1,
        CH_RIGHT = 2'd2,
        CH_BOTH  = 2'd3
    } ch_mode_e;

    // Slot-mapping settings captured at each codec period boundary
    typedef struct packed {
        ch_mode_e mode;
        logic     swap;
    } slot_cfg_t;

    localparam slot_cfg_t SLOT_CFG_RST = '{mode: CH_BOTH, swap: 1'b0};

    localparam int NUM_CH  = 2;
    localparam int OSR_MIN = 32;

    // Codec periods per PCM sample for an oversampling select code
    function automatic int osr_len(input logic [1:0] sel);
        return OSR_MIN << sel;
    endfunction

endpackage

// File: rtl/pdmspk_phase.sv
module pdmspk_phase (
    input  logic clk,
    input  logic rst,
    output logic half_o,
    output logic bound_o,
    output logic idle_o,
    output logic codec_clk_o
);
    logic [1:0] ph_q;
    logic       idle_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q   <= 2'd0;
            idle_q <= 1'b0;
        end else begin
            ph_q <= ph_q + 2'd1;
            if (ph_q == 2'd3) idle_q <= ~idle_q;
        end
    end

    assign half_o      = ph_q[1];
    assign bound_o     = (ph_q == 2'd3);
    assign idle_o      = idle_q;
    assign codec_clk_o = ~ph_q[1];

    // R1: two cycles high, two cycles low, repeating
    p_clk_shape_r1: assert property (@(posedge clk) disable iff (rst)
        $rose(codec_clk_o) |=> codec_clk_o ##1 !codec_clk_o ##1 !codec_clk_o ##1 codec_clk_o);

endmodule

// File: rtl/pdmspk_sdm.sv
module pdmspk_sdm #(
    parameter int IN_W  = 24,
    parameter int ACC_W = 32
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            step,
    input  logic            clr,
    input  logic [IN_W-1:0] x_i,
    output logic            bit_o
);
    localparam logic signed [ACC_W-1:0] FULL = ACC_W'(1) << (IN_W - 1);

    logic signed [ACC_W-1:0] i1_q, i2_q, i1_n, i2_n, fb, x_ext;
    logic                    y;

    assign x_ext = {{(ACC_W - IN_W){x_i[IN_W-1]}}, x_i};
    assign y     = ~i2_q[ACC_W-1];
    assign fb    = y ? FULL : -FULL;
    assign i1_n  = i1_q + x_ext - fb;
    assign i2_n  = i2_q + i1_n - fb;

    always_ff @(posedge clk) begin
        if (rst) begin
            i1_q  <= '0;
            i2_q  <= '0;
            bit_o <= 1'b0;
        end else if (step) begin
            if (clr) begin
                i1_q  <= '0;
                i2_q  <= '0;
                bit_o <= 1'b0;
            end else begin
                i1_q  <= i1_n;
                i2_q  <= i2_n;
                bit_o <= y;
            end
        end
    end

    // R4: the modulator bit only changes on a step
    p_bit_hold_r4: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(bit_o));

    // R8: a clearing step leaves the integrators at zero
    p_clear_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (step && clr) |=> (i1_q == '0 && i2_q == '0 && !bit_o));

endmodule

// File: rtl/pdmspk_top.sv
module pdmspk_top
    import pdmspk_pkg::*;
#(
    parameter int SAMPLE_W = 24,
    parameter int ACC_W    = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                en_i,
    input  logic [1:0]          osr_sel_i,
    input  logic [1:0]          ch_sel_i,
    input  logic                lr_swap_i,
    input  logic                fifo_valid_i,
    input  logic [SAMPLE_W-1:0] fifo_left_i,
    input  logic [SAMPLE_W-1:0] fifo_right_i,
    output logic                fifo_pop_o,
    output logic                codec_clk_o,
    output logic                pdm_dat_o,
    output logic                underflow_o
);
    localparam int CNT_W = $clog2(OSR_MIN << 3) + 1;

    logic half_w, bound_w, idle_w;

    pdmspk_phase u_phase (
        .clk         (clk),
        .rst         (rst),
        .half_o      (half_w),
        .bound_o     (bound_w),
        .idle_o      (idle_w),
        .codec_clk_o (codec_clk_o)
    );

    slot_cfg_t                         cfg_q;
    logic                              run_q;
    logic [CNT_W-1:0]                  cnt_q;
    logic [NUM_CH-1:0][SAMPLE_W-1:0]   samp_q;
    logic [NUM_CH-1:0][SAMPLE_W-1:0]   head_w;
    logic [NUM_CH-1:0][SAMPLE_W-1:0]   x_w;
    logic [NUM_CH-1:0]                 bit_w;
    logic                              load_w, clr_w, last_w;

    assign head_w[0]  = fifo_left_i;
    assign head_w[1]  = fifo_right_i;
    assign load_w     = bound_w && en_i && (cnt_q == '0);
    assign fifo_pop_o = load_w && fifo_valid_i;
    assign clr_w      = !en_i;
    assign last_w     = (cnt_q >= CNT_W'(osr_len(osr_sel_i) - 1));

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q       <= SLOT_CFG_RST;
            run_q       <= 1'b0;
            cnt_q       <= '0;
            samp_q      <= '0;
            underflow_o <= 1'b0;
        end else if (bound_w) begin
            run_q      <= en_i;
            cfg_q.mode <= ch_mode_e'(ch_sel_i);
            cfg_q.swap <= lr_swap_i;
            if (!en_i) begin
                cnt_q       <= '0;
                underflow_o <= 1'b0;
            end else begin
                cnt_q <= last_w ? '0 : cnt_q + CNT_W'(1);
                if (fifo_pop_o)  samp_q      <= head_w;
                else if (load_w) underflow_o <= 1'b1;
            end
        end
    end

    // One modulator per channel; each steps at every period boundary
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        assign x_w[c] = fifo_pop_o ? head_w[c] : samp_q[c];
        pdmspk_sdm #(.IN_W(SAMPLE_W), .ACC_W(ACC_W)) u_sdm (
            .clk   (clk),
            .rst   (rst),
            .step  (bound_w),
            .clr   (clr_w),
            .x_i   (x_w[c]),
            .bit_o (bit_w[c])
        );
    end

    // Slot mapping: channel index 0 = left, 1 = right
    logic slot_ch, slot_on;

    always_comb begin
        slot_ch = half_w ^ cfg_q.swap;
        unique case (cfg_q.mode)
            CH_LEFT:  slot_on = (slot_ch == 1'b0);
            CH_RIGHT: slot_on = (slot_ch == 1'b1);
            default:  slot_on = 1'b1;
        endcase
        pdm_dat_o = (run_q && slot_on) ? bit_w[slot_ch] : idle_w;
    end

    // R10: pops only with data, in the last low cycle of a period
    p_pop_valid_r10: assert property (@(posedge clk) disable iff (rst)
        fifo_pop_o |-> (fifo_valid_i && !codec_clk_o));

    p_pop_edge_r10: assert property (@(posedge clk) disable iff (rst)
        fifo_pop_o |=> codec_clk_o);

    // R7: the underflow flag cannot drop while enabled
    p_uf_sticky_r7: assert property (@(posedge clk) disable iff (rst)
        (underflow_o && en_i) |=> underflow_o);

    // R8: a stopped block shows the same bit in both halves
    p_idle_halves_r8: assert property (@(posedge clk) disable iff (rst)
        (!run_q && !codec_clk_o && $past(codec_clk_o)) |-> (pdm_dat_o == $past(pdm_dat_o)));

endmodule

// File: tb/tb_pdmspk_top.sv
module tb_pdmspk_top;
    localparam int W       = 24;
    localparam int HALF_NS = 10;   // 50 MHz core clock

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         en = 1'b0;
    logic [1:0]   osr = 2'd1;
    logic [1:0]   chs = 2'd3;
    logic         swp = 1'b0;
    logic         valid = 1'b0;
    logic [W-1:0] f_left, f_right;
    logic         pop, cclk, dat, uf;

    int checks = 0;
    int errors = 0;
    int k = 0;
    bit done = 0;

    always #HALF_NS clk = ~clk;

    assign f_left  = W'(((k * 37) % 200 - 100) * 20000);
    assign f_right = W'(((k * 53) % 160 - 80) * 25000);

    pdmspk_top #(.SAMPLE_W(W), .ACC_W(32)) dut (
        .clk(clk), .rst(rst), .en_i(en), .osr_sel_i(osr), .ch_sel_i(chs),
        .lr_swap_i(swp), .fifo_valid_i(valid), .fifo_left_i(f_left),
        .fifo_right_i(f_right), .fifo_pop_o(pop), .codec_clk_o(cclk),
        .pdm_dat_o(dat), .underflow_o(uf)
    );

    task automatic chk(input longint act, input longint exp, input string tag);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Behavioural reference model, advanced at each rising edge
    int     m_ph = 0, m_cnt = 0, m_ch = 3, m_pol = 0;
    bit     m_run = 0, m_t = 0, m_uf = 0;
    longint m_a1[2], m_a2[2], m_smp[2];
    bit     m_bit[2];

    always @(posedge clk) begin
        if (rst) begin
            m_ph = 0; m_cnt = 0; m_ch = 3; m_pol = 0;
            m_run = 0; m_t = 0; m_uf = 0;
            for (int c = 0; c < 2; c++) begin
                m_a1[c] = 0; m_a2[c] = 0; m_smp[c] = 0; m_bit[c] = 0;
            end
        end else begin
            if (m_ph == 3) begin
                m_t = !m_t;
                m_run = en;
                m_ch = int'(chs);
                m_pol = int'(swp);
                if (!en) begin
                    m_cnt = 0; m_uf = 0;
                    for (int c = 0; c < 2; c++) begin
                        m_a1[c] = 0; m_a2[c] = 0; m_bit[c] = 0;
                    end
                end else begin
                    if (m_cnt == 0) begin
                        if (valid) begin
                            m_smp[0] = longint'($signed(f_left));
                            m_smp[1] = longint'($signed(f_right));
                            k <= k + 1;
                        end else begin
                            m_uf = 1;
                        end
                    end
                    for (int c = 0; c < 2; c++) begin
                        bit y;
                        longint fb;
                        y = (m_a2[c] >= 0);
                        fb = y ? (64'sd1 <<< 23) : -(64'sd1 <<< 23);
                        m_a1[c] = m_a1[c] + m_smp[c] - fb;
                        m_a2[c] = m_a2[c] + m_a1[c] - fb;
                        m_bit[c] = y;
                    end
                    m_cnt = (m_cnt >= (32 << osr) - 1) ? 0 : m_cnt + 1;
                end
            end
            m_ph = (m_ph + 1) % 4;
        end
    end

    // Cycle-by-cycle comparison at the falling edge
    int cyc = 0, prev_cyc = 0, prev_osr = 0;
    bit have_prev = 0;

    always @(negedge clk) begin
        if (!rst && !done) begin
            int  half, chan;
            bit  on, exp_dat, exp_pop;
            string tag;
            cyc++;
            half = (m_ph >= 2) ? 1 : 0;
            chan = half ^ m_pol;
            on = (m_ch == 1) ? (chan == 0) : (m_ch == 2) ? (chan == 1) : 1'b1;
            exp_dat = (m_run && on) ? m_bit[chan] : m_t;
            exp_pop = (m_ph == 3) && en && (m_cnt == 0) && valid;
            if (!m_run) tag = "R8 data";
            else if (m_ch == 1 || m_ch == 2) tag = "R4 R6 data";
            else tag = "R4 R5 data";
            if (m_run != en) tag = {tag, " R9"};
            chk(cclk, (m_ph < 2), "R1 codec clock");
            chk(pop, exp_pop, "R10 pop");
            chk(uf, m_uf, "R7 underflow");
            chk(dat, exp_dat, tag);
            if (pop) begin
                if (have_prev && prev_osr == int'(osr))
                    chk(cyc - prev_cyc, 4 * (32 << osr), "R2 pop spacing");
                have_prev = 1; prev_cyc = cyc; prev_osr = int'(osr);
            end
            if (!en || !valid) have_prev = 0;
        end
    end

    task automatic wait_cyc(input int n);
        repeat (n) @(negedge clk);
        #2;
    endtask

    task automatic to_phase(input int p);
        while (m_ph != p) wait_cyc(1);
    endtask

    initial begin
        wait_cyc(4);
        rst = 1'b0;
        @(negedge clk); #1;
        // R3: reset state
        chk(cclk, 1, "R3 codec clock");
        chk(dat, 0, "R3 data");
        chk(pop, 0, "R3 pop");
        chk(uf, 0, "R3 underflow");
        wait_cyc(6);

        // Stereo, left first, ratio 64
        valid = 1; osr = 2'd1; chs = 2'd3; swp = 0;
        to_phase(1);
        en = 1;
        @(negedge clk); #1;
        chk(dat, m_t, "R9 idle before boundary");
        @(negedge clk); #1;
        chk(pop, 1, "R9 pop at first boundary");
        wait_cyc(4 * 64 * 3);

        // Stereo, right first, ratio 32
        osr = 2'd0; swp = 1;
        wait_cyc(4 * 32 * 4);

        // Left only, ratio 128
        chs = 2'd1; swp = 0; osr = 2'd2;
        wait_cyc(4 * 128 * 3);

        // Right only, right first, ratio 32
        chs = 2'd2; swp = 1; osr = 2'd0;
        wait_cyc(4 * 32 * 3);
        chs = 2'd2; swp = 0;
        wait_cyc(4 * 32 * 2);

        // Underflow: FIFO runs dry for two load points
        chs = 2'd3; swp = 0; osr = 2'd1;
        wait_cyc(4 * 64);
        valid = 0;
        wait_cyc(4 * 64 * 2 + 8);
        chk(uf, 1, "R7 flag after starvation");
        valid = 1;
        wait_cyc(4 * 64 * 2);
        chk(uf, 1, "R7 flag still set");

        // Disable mid period
        to_phase(0);
        en = 0;
        wait_cyc(8);
        chk(uf, 0, "R8 flag cleared");
        wait_cyc(40);

        // Ratio 256, stereo
        osr = 2'd3; chs = 2'd3;
        to_phase(2);
        en = 1;
        wait_cyc(4 * 256 * 2 + 20);
        en = 0;
        wait_cyc(20);

        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule